// File: doc/BRIEF.md
# Periodic Temperature Acquisition Controller

This block decides when a thermistor reading is taken and turns each reading into a signed temperature byte. A free-running timer raises a conversion request once per period, which is 60 seconds of system clock by default. The request goes to an external 10-bit converter. The converter answers with a one-cycle completion pulse and a code. That code is mapped through a monotonic breakpoint curve with linear interpolation into whole degrees Celsius. The result is then stored in a readout register, and the serial-bus logic presents that register to hosts.

Serial-bus traffic always takes priority. While the bus reports a transaction in flight, a running conversion is dropped and a new one is not started. Once the bus goes quiet the request is raised again. Only a conversion that runs to completion with the bus idle may change the stored byte. If the bus is kept busy with gaps shorter than a conversion, the stored byte therefore stays frozen at its last value.

Top module: `temp_sched`

## Requirements
- R1: After reset `tempOut` is 0x00. `adcReq` is high after the first clock edge following reset release, and `tempOut` stays 0x00 until that first conversion completes.
- R2: With the bus idle, successive rising edges of `adcReq` are exactly `PERIOD_TICKS` clock cycles apart.
- R3: `adcReq` is a level that stays high until `adcDone` is sampled high. On that edge, with `busBusy` low, `tempOut` takes the new value and `adcReq` falls.
- R4: `tempOut` is two's complement, one LSB per degree (0 °C = 0x00, -1 °C = 0xFF, 25 °C = 0x19). Breakpoint k (of `NUM_BP`, code at bits k*10 upward in `BP_CODES`, codes strictly falling) marks temperature `TEMP_MIN + k*STEP`, where STEP = (TEMP_MAX-TEMP_MIN)/(NUM_BP-1). A code c with bp[k] >= c > bp[k+1] maps to `TEMP_MIN + k*STEP + floor((bp[k]-c)*STEP/(bp[k]-bp[k+1]))`.
- R5: A code at or above the first breakpoint reads 0xF6 (-10 °C). A code at or below the last breakpoint reads 0x55 (85 °C). No stored value lies outside that window.
- R6: If `busBusy` is high while a conversion runs, `adcReq` is low after the next edge and `tempOut` keeps its previous value.
- R7: After an abort, `adcReq` rises on the first clock edge at which `busBusy` is sampled low, one clock after it falls. The restarted conversion then stores its result.
- R8: An `adcDone` pulse sampled together with `busBusy` high is discarded. The conversion is treated as aborted and is restarted when the bus goes idle.
- R9: If bus transactions repeat with idle gaps shorter than one conversion time, `tempOut` never changes. The first uninterrupted conversion afterwards updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busBusy | input | 1 | High from bus START to STOP |
| adcReq | output | 1 | Conversion request level to the converter; dropping it aborts |
| adcDone | input | 1 | One-cycle completion pulse from the converter |
| adcCode | input | CODE_W | Converter result, valid with `adcDone` |
| tempOut | output | TEMP_W | Stored signed temperature byte |

## Verification
Two events can land in the same cycle: a conversion finishing and a bus transaction starting. The bench's converter model counts conversion cycles, so the bench can raise `busBusy` on exactly the clock in which the model pulses `adcDone`. The result is judged at the ports. The stored byte must keep its old value, the request must drop one cycle later, and after the bus goes idle a restarted conversion must deliver the new code's temperature.

// File: rtl/temp_sched_pkg.sv
package temp_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } acqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } dpStrobe_t;
endpackage

// File: rtl/temp_sched_ctrl.sv
module temp_sched_ctrl
  import temp_sched_pkg::*;
#(
  parameter logic [39:0] PERIOD_TICKS = 40'd7_500_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busBusy,
  input  logic      adcDone,
  output logic      adcReq,
  output dpStrobe_t strobe
);
  localparam int CNT_W = $clog2(PERIOD_TICKS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD_TICKS - 40'd1);

  logic [CNT_W-1:0] tickCnt;
  logic periodTick;
  logic pendingQ;
  logic startNow;
  acqState_e stateQ, stateD;

  // free-running period timer, independent of bus traffic
  assign periodTick = (tickCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tickCnt <= '0;
    else if (periodTick) tickCnt <= '0;
    else                 tickCnt <= tickCnt + 1'b1;
  end

  // pending trigger: set at reset so the first conversion starts at once
  assign startNow = (stateQ == ST_IDLE) && pendingQ && !busBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pendingQ <= 1'b1;
    else if (startNow)   pendingQ <= periodTick;
    else if (periodTick) pendingQ <= 1'b1;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startNow) stateD = ST_CONV;
      ST_CONV: begin
        if (busBusy)      stateD = ST_HOLD;
        else if (adcDone) stateD = ST_IDLE;
      end
      ST_HOLD: if (!busBusy) stateD = ST_CONV;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign adcReq      = (stateQ == ST_CONV);
  assign strobe.load = (stateQ == ST_CONV) && adcDone && !busBusy;

  p_timer_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= LAST_CNT);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (adcReq && !adcDone && !busBusy) |=> adcReq);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONV && busBusy) |=> !adcReq);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && !busBusy) |=> adcReq);
endmodule

// File: rtl/temp_sched_dp.sv
module temp_sched_dp
  import temp_sched_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int TEMP_W = 8,
  parameter int NUM_BP = 6,
  parameter logic [NUM_BP*CODE_W-1:0] BP_CODES =
    {10'd140, 10'd260, 10'd420, 10'd600, 10'd780, 10'd920},
  parameter int TEMP_MIN = -10,
  parameter int TEMP_MAX = 85
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] adcCode,
  output logic [TEMP_W-1:0] tempOut
);
  localparam int NUM_SEG = NUM_BP - 1;
  localparam int STEP    = (TEMP_MAX - TEMP_MIN) / NUM_SEG;
  localparam int PROD_W  = CODE_W + $clog2(STEP + 1);
  localparam logic [CODE_W-1:0] FIRST_BP = BP_CODES[CODE_W-1:0];

  logic [NUM_SEG-1:0] segHit;
  logic [TEMP_W-1:0]  segTemp [NUM_SEG];
  logic [TEMP_W-1:0]  mapped;
  logic [TEMP_W-1:0]  tempQ;

  // one interpolator per segment between neighbouring breakpoints
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [CODE_W-1:0] HI = BP_CODES[s*CODE_W +: CODE_W];
    localparam logic [CODE_W-1:0] LO = BP_CODES[(s+1)*CODE_W +: CODE_W];
    localparam int SPAN = int'(HI) - int'(LO);
    localparam logic [TEMP_W-1:0] BASE = TEMP_W'(TEMP_MIN + s*STEP);
    logic [CODE_W-1:0] delta;
    logic [PROD_W-1:0] scaled;
    assign segHit[s]  = (adcCode <= HI) && (adcCode > LO);
    assign delta      = HI - adcCode;
    assign scaled     = PROD_W'(delta) * PROD_W'(STEP);
    assign segTemp[s] = BASE + TEMP_W'(scaled / PROD_W'(SPAN));
  end

  // saturate outside the breakpoint range, else pick the hit segment
  always_comb begin
    mapped = TEMP_W'(TEMP_MAX);
    if (adcCode >= FIRST_BP) begin
      mapped = TEMP_W'(TEMP_MIN);
    end else begin
      for (int s = 0; s < NUM_SEG; s++)
        if (segHit[s]) mapped = segTemp[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tempQ <= '0;
    else if (strobe.load) tempQ <= mapped;
  end

  assign tempOut = tempQ;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(tempQ));

  p_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(tempQ) >= $signed(TEMP_W'(TEMP_MIN))) &&
    ($signed(tempQ) <= $signed(TEMP_W'(TEMP_MAX))));
endmodule

// File: rtl/temp_sched.sv
module temp_sched
  import temp_sched_pkg::*;
#(
  parameter logic [39:0] PERIOD_TICKS = 40'd7_500_000_000,
  parameter int CODE_W = 10,
  parameter int TEMP_W = 8,
  parameter int NUM_BP = 6,
  parameter logic [NUM_BP*CODE_W-1:0] BP_CODES =
    {10'd140, 10'd260, 10'd420, 10'd600, 10'd780, 10'd920},
  parameter int TEMP_MIN = -10,
  parameter int TEMP_MAX = 85
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busBusy,
  output logic              adcReq,
  input  logic              adcDone,
  input  logic [CODE_W-1:0] adcCode,
  output logic [TEMP_W-1:0] tempOut
);
  dpStrobe_t strobe;

  temp_sched_ctrl #(
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busBusy(busBusy),
    .adcDone(adcDone),
    .adcReq (adcReq),
    .strobe (strobe)
  );

  temp_sched_dp #(
    .CODE_W  (CODE_W),
    .TEMP_W  (TEMP_W),
    .NUM_BP  (NUM_BP),
    .BP_CODES(BP_CODES),
    .TEMP_MIN(TEMP_MIN),
    .TEMP_MAX(TEMP_MAX)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .adcCode(adcCode),
    .tempOut(tempOut)
  );
endmodule

// File: tb/temp_sched_bench.sv
module temp_sched_bench;
  localparam int PERIOD   = 400;
  localparam int CONV_CYC = 20;
  localparam int NVEC     = 13;

  typedef struct packed {
    logic [9:0] code;
    logic [7:0] exp;
  } vec_t;

  // R4 interpolation points and R5 saturation points
  localparam vec_t VECS [NVEC] = '{
    '{10'd1000, 8'hF6}, '{10'd920, 8'hF6}, '{10'd919, 8'hF6},
    '{10'd850,  8'hFF}, '{10'd846, 8'h00}, '{10'd780, 8'h09},
    '{10'd628,  8'h19}, '{10'd500, 8'h26}, '{10'd300, 8'h3D},
    '{10'd200,  8'h4B}, '{10'd141, 8'h54}, '{10'd140, 8'h55},
    '{10'd5,    8'h55}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busBusy = 1'b0;
  logic adcDone = 1'b0;
  logic [9:0] adcCode = 10'd733;
  logic adcReq;
  logic [7:0] tempOut;
  int cyc = 0;
  int stubCnt = 0;
  int nChecks = 0;
  int nFails = 0;
  bit ended = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  temp_sched #(.PERIOD_TICKS(40'(PERIOD))) u_temp_sched (
    .clk(clk), .rstN(rstN), .busBusy(busBusy), .adcReq(adcReq),
    .adcDone(adcDone), .adcCode(adcCode), .tempOut(tempOut)
  );

  // converter model: completes after CONV_CYC cycles of uninterrupted request
  always @(negedge clk) begin
    if (!adcReq) begin
      stubCnt <= 0; adcDone <= 1'b0;
    end else if (adcDone) begin
      stubCnt <= 0; adcDone <= 1'b0;
    end else if (stubCnt == CONV_CYC - 1) begin
      adcDone <= 1'b1;
    end else begin
      stubCnt <= stubCnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!adcReq);
  endtask

  task automatic waitDone();
    do @(negedge clk); while (adcReq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int startCyc;
    int prevStart;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset value", 32'(tempOut), 32'h00);
    @(negedge clk);
    check("R1 immediate request", 32'(adcReq), 32'd1);
    check("R1 zero before completion", 32'(tempOut), 32'h00);
    waitDone();
    check("R1 first result", 32'(tempOut), 32'h0D);

    // table walk: one periodic conversion per vector
    prevStart = 0;
    for (int i = 0; i < NVEC; i++) begin
      adcCode = VECS[i].code;
      waitStart();
      startCyc = cyc;
      if (i > 0) check("R2 period", 32'(startCyc - prevStart), 32'(PERIOD));
      prevStart = startCyc;
      waitDone();
      if (i == 0) check("R3 request length", 32'(cyc - startCyc), 32'(CONV_CYC));
      check((VECS[i].code >= 10'd920 || VECS[i].code <= 10'd140) ? "R5 saturate" : "R4 map",
            32'(tempOut), 32'(VECS[i].exp));
    end

    // R6/R7: abort mid conversion and restart after the bus goes idle
    adcCode = 10'd500;
    waitStart();
    repeat (5) @(negedge clk);
    busBusy = 1'b1;
    @(negedge clk);
    check("R6 request dropped", 32'(adcReq), 32'd0);
    repeat (30) @(negedge clk);
    check("R6 value kept", 32'(tempOut), 32'h55);
    busBusy = 1'b0;
    check("R7 no early restart", 32'(adcReq), 32'd0);
    @(negedge clk);
    check("R7 restart one clock later", 32'(adcReq), 32'd1);
    waitDone();
    check("R7 restarted result", 32'(tempOut), 32'h26);

    // R8: completion and bus start in the same cycle
    adcCode = 10'd300;
    waitStart();
    repeat (CONV_CYC - 1) @(negedge clk);
    busBusy = 1'b1;
    @(negedge clk);
    check("R8 request dropped", 32'(adcReq), 32'd0);
    check("R8 completion discarded", 32'(tempOut), 32'h26);
    repeat (3) @(negedge clk);
    busBusy = 1'b0;
    waitDone();
    check("R8 result after restart", 32'(tempOut), 32'h3D);

    // R9: bus traffic with short gaps starves updates
    adcCode = 10'd141;
    waitStart();
    for (int r = 0; r < 40; r++) begin
      busBusy = 1'b1;
      repeat (3) @(negedge clk);
      busBusy = 1'b0;
      repeat (CONV_CYC - 5) @(negedge clk);
    end
    check("R9 frozen under traffic", 32'(tempOut), 32'h3D);
    waitDone();
    check("R9 update after traffic", 32'(tempOut), 32'h54);

    finishRun();
  end
endmodule